// File: doc/BRIEF.md
# Snoop Response Combiner

On a shared coherence bus every cache snoops each miss. This block takes the per-cache snoop replies and reduces them to three bus-wide lines: *some other cache holds the line*, *some other cache holds it exclusively*, and *every other cache has finished snooping*. All three are pure combinational reductions, because the requester waits on them while it resolves a miss.

A transaction opens on a one-cycle start pulse that carries the index of the requesting cache. The requester's own reply is masked out of all three reductions. Its completion bit is treated as already finished. On the first cycle that completion is seen, the block captures the shared and exclusive lines into a result register. It then raises a one-cycle valid pulse. It also records a protocol-error flag when an exclusive copy exists alongside a second holder.

Top module: `snoop_combine`

## Requirements
- R1: After reset, `res_valid_o`, `res_shared_o`, `res_excl_o`, `res_err_o` and `bus_done_o` are 0, and the requester index is 0.
- R2: `bus_shared_o` is the OR of `snp_hit_i[i]` over every cache i other than the current requester. The requester's own hit bit has no effect.
- R3: `bus_excl_o` is the OR of `snp_excl_i[i]` over every cache i other than the current requester.
- R4: `bus_done_o` is 1 only while a transaction is open and every non-requester cache has its `snp_done_i` bit at 1. The requester's own done bit has no effect. The line is 0 when no transaction is open.
- R5: The three bus lines follow their inputs in the same cycle, with no register stage.
- R6: In the clock edge where `bus_done_o` is 1, the result register captures the bus lines. `res_valid_o` is then 1 for exactly one cycle. `res_shared_o`, `res_excl_o` and `res_err_o` hold their captured values until the next start.
- R7: A transaction is captured at most once. After capture, `bus_done_o` goes to 0 and no further valid pulse is raised, even if the done inputs stay high.
- R8: A start pulse (`start_i` = 1) loads `start_id_i` as the requester index, where bit i of each input vector belongs to cache i. It opens a transaction and clears all three result bits to 0 from the next cycle.
- R9: `res_err_o` is captured as 1 when the exclusive line is asserted and at least two non-requester caches report holding the line. A cache holds the line when its hit or exclusive bit is 1.
- R10: When a start pulse and completion fall in the same cycle, the start wins. The old transaction is dropped without a valid pulse, and the new one opens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Opens a new transaction |
| start_id_i | input | IDW | Requester index, loaded on start |
| snp_hit_i | input | N_CACHE | Per-cache: holds a copy |
| snp_excl_i | input | N_CACHE | Per-cache: copy is exclusive |
| snp_done_i | input | N_CACHE | Per-cache: snoop finished |
| bus_shared_o | output | 1 | Combined shared line |
| bus_excl_o | output | 1 | Combined exclusive line |
| bus_done_o | output | 1 | All other snoopers finished |
| res_valid_o | output | 1 | One-cycle result pulse |
| res_shared_o | output | 1 | Captured shared result |
| res_excl_o | output | 1 | Captured exclusive result |
| res_err_o | output | 1 | Captured protocol-error flag |

## Verification
The start pulse and the completion capture can land on the same clock edge. Start must win, so the abandoned transaction produces no result. The bench provokes this by raising every done bit in the same cycle as a new start with a different requester. It then judges the outcome at the ports: no valid pulse appears for the dropped request, the result bits read as cleared, and the only result that follows matches the new requester's mask. The scoreboard reports any unexpected pulse as a failure.

// File: rtl/snp_pkg.sv
// Shared types for the snoop response combiner.
package snp_pkg;
    // Captured resolution of one snoop transaction.
    typedef struct packed {
        logic shared;
        logic excl;
        logic err;
    } snp_result_t;
endpackage

// File: rtl/snp_req_mask.sv
// Decodes the requester index into a one-hot exclusion mask.
// Assumes the index is below N_CACHE. Out-of-range values give an empty mask.
module snp_req_mask #(
    parameter int N_CACHE = 4,
    parameter int IDW     = $clog2(N_CACHE)
) (
    input  logic [IDW-1:0]     id_i,
    output logic [N_CACHE-1:0] mask_o
);
    // One comparator per cache position.
    for (genvar g = 0; g < N_CACHE; g++) begin : g_dec
        assign mask_o[g] = (id_i == IDW'(g));
    end
endmodule

// File: rtl/snp_resp_or.sv
// Combinational reduction of per-cache snoop replies with requester masking.
// Produces the shared, exclusive and all-done lines plus a multi-holder error term.
// Assumes mask_in is one-hot or zero. Has no state.
module snp_resp_or #(
    parameter int N_CACHE = 4
) (
    input  logic [N_CACHE-1:0] hit_i,
    input  logic [N_CACHE-1:0] excl_i,
    input  logic [N_CACHE-1:0] done_i,
    input  logic [N_CACHE-1:0] mask_i,
    input  logic               active_i,
    output logic               shared_o,
    output logic               excl_o,
    output logic               done_o,
    output logic               err_o
);
    logic [N_CACHE-1:0] hit_m, excl_m, done_m, hold_m;
    logic [N_CACHE:0]   seen, multi;

    assign hit_m  = hit_i  & ~mask_i;
    assign excl_m = excl_i & ~mask_i;
    assign done_m = done_i |  mask_i;
    assign hold_m = hit_m  |  excl_m;

    assign seen[0]  = 1'b0;
    assign multi[0] = 1'b0;
    // Ripple chain that flags a second holder without a full popcount.
    for (genvar g = 0; g < N_CACHE; g++) begin : g_multi
        assign seen[g+1]  = seen[g]  | hold_m[g];
        assign multi[g+1] = multi[g] | (seen[g] & hold_m[g]);
    end

    assign shared_o = |hit_m;
    assign excl_o   = |excl_m;
    assign done_o   = active_i & (&done_m);
    assign err_o    = (|excl_m) & multi[N_CACHE];
endmodule

// File: rtl/snp_result_reg.sv
// Holds the requester index and the open-transaction flag.
// Captures the result once per transaction. Start takes priority over capture.
module snp_result_reg #(
    parameter int N_CACHE = 4,
    parameter int IDW     = $clog2(N_CACHE)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic [IDW-1:0]            start_id_i,
    input  logic                      done_i,
    input  snp_pkg::snp_result_t      comb_i,
    output logic [IDW-1:0]            id_o,
    output logic                      active_o,
    output logic                      valid_o,
    output snp_pkg::snp_result_t      res_o
);
    // Transaction bookkeeping and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_o     <= '0;
            active_o <= 1'b0;
            valid_o  <= 1'b0;
            res_o    <= '0;
        end else begin
            valid_o <= 1'b0;
            if (start_i) begin
                id_o     <= start_id_i;
                active_o <= 1'b1;
                res_o    <= '0;
            end else if (done_i) begin
                active_o <= 1'b0;
                valid_o  <= 1'b1;
                res_o    <= comb_i;
            end
        end
    end
endmodule

// File: rtl/snoop_combine.sv
// Top of the snoop response combiner.
// Bus lines are combinational from the inputs and the registered requester mask.
// The result is registered. N_CACHE must be at least 2.
module snoop_combine #(
    parameter int N_CACHE = 4,
    localparam int IDW    = $clog2(N_CACHE)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [IDW-1:0]     start_id_i,
    input  logic [N_CACHE-1:0] snp_hit_i,
    input  logic [N_CACHE-1:0] snp_excl_i,
    input  logic [N_CACHE-1:0] snp_done_i,
    output logic               bus_shared_o,
    output logic               bus_excl_o,
    output logic               bus_done_o,
    output logic               res_valid_o,
    output logic               res_shared_o,
    output logic               res_excl_o,
    output logic               res_err_o
);
    logic [IDW-1:0]       id_q;
    logic                 active_q;
    logic [N_CACHE-1:0]   mask;
    logic                 err_c;
    snp_pkg::snp_result_t comb_res, res_q;

    snp_req_mask #(.N_CACHE(N_CACHE), .IDW(IDW)) u_mask (
        .id_i   (id_q),
        .mask_o (mask)
    );

    snp_resp_or #(.N_CACHE(N_CACHE)) u_or (
        .hit_i    (snp_hit_i),
        .excl_i   (snp_excl_i),
        .done_i   (snp_done_i),
        .mask_i   (mask),
        .active_i (active_q),
        .shared_o (bus_shared_o),
        .excl_o   (bus_excl_o),
        .done_o   (bus_done_o),
        .err_o    (err_c)
    );

    // Bundle the combinational lines for capture.
    always_comb begin
        comb_res.shared = bus_shared_o;
        comb_res.excl   = bus_excl_o;
        comb_res.err    = err_c;
    end

    snp_result_reg #(.N_CACHE(N_CACHE), .IDW(IDW)) u_res (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .start_id_i (start_id_i),
        .done_i     (bus_done_o),
        .comb_i     (comb_res),
        .id_o       (id_q),
        .active_o   (active_q),
        .valid_o    (res_valid_o),
        .res_o      (res_q)
    );

    assign res_shared_o = res_q.shared;
    assign res_excl_o   = res_q.excl;
    assign res_err_o    = res_q.err;
endmodule

// File: rtl/snoop_combine_chk.sv
// Port-level protocol checks for the snoop response combiner.
module snoop_combine_chk #(
    parameter int N_CACHE = 4,
    localparam int IDW    = $clog2(N_CACHE)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic [IDW-1:0]     start_id_i,
    input logic [N_CACHE-1:0] snp_hit_i,
    input logic               bus_excl_o,
    input logic               bus_done_o,
    input logic               res_valid_o,
    input logic               res_shared_o,
    input logic               res_excl_o,
    input logic               res_err_o
);
    // R6: the valid indication is a single-cycle pulse.
    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |=> !res_valid_o);

    // R6, R10: a pulse follows completion with no competing start.
    p_valid_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_done_o && !start_i) |=> res_valid_o);

    // R8: start clears the result and suppresses the pulse.
    p_start_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!res_valid_o && !res_shared_o && !res_excl_o && !res_err_o));

    // R6: the result holds while nothing completes or starts.
    p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !bus_done_o) |=> ($stable(res_shared_o) && $stable(res_excl_o) && $stable(res_err_o)));

    // R7: completion is seen once, then the transaction closes.
    p_single_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_done_o && !start_i) |=> !bus_done_o);

    // R9: an error can only be recorded together with an exclusive result.
    p_err_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        res_err_o |-> res_excl_o);
endmodule

bind snoop_combine snoop_combine_chk #(.N_CACHE(N_CACHE)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .start_id_i   (start_id_i),
    .snp_hit_i    (snp_hit_i),
    .bus_excl_o   (bus_excl_o),
    .bus_done_o   (bus_done_o),
    .res_valid_o  (res_valid_o),
    .res_shared_o (res_shared_o),
    .res_excl_o   (res_excl_o),
    .res_err_o    (res_err_o)
);

// File: tb/tb_snoop_combine.sv
// Scoreboard bench for snoop_combine: the driver queues expected results, the monitor checks pulses.
module tb_snoop_combine;
    localparam int N   = 4;
    localparam int IDW = $clog2(N);

    logic           clk = 1'b0;
    logic           rst_n;
    logic           start_i;
    logic [IDW-1:0] start_id_i;
    logic [N-1:0]   snp_hit_i, snp_excl_i, snp_done_i;
    logic           bus_shared_o, bus_excl_o, bus_done_o;
    logic           res_valid_o, res_shared_o, res_excl_o, res_err_o;

    int checks = 0;
    int errors = 0;
    logic [2:0] expq[$];   // {shared, excl, err}

    always #10 clk = ~clk;   // 50 MHz

    snoop_combine #(.N_CACHE(N)) dut (.*);

    task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic logic [2:0] model(input int id, input logic [N-1:0] h, input logic [N-1:0] x);
        logic [N-1:0] m, hm, xm;
        m  = N'(1) << id;
        hm = h & ~m;
        xm = x & ~m;
        return {|hm, |xm, (|xm) && ($countones(hm | xm) >= 2)};
    endfunction

    // Monitor: compares each valid pulse against the head of the queue.
    always @(posedge clk) begin
        #5;
        if (rst_n && res_valid_o) begin
            if (expq.size() == 0) begin
                chk("R7/R10 unexpected valid", 3'b001, 3'b000);
            end else begin
                logic [2:0] e;
                e = expq.pop_front();
                chk("R6/R9 captured result", {res_shared_o, res_excl_o, res_err_o}, e);
            end
        end
    end

    // Runs a full transaction; the requester's own done bit stays 0 to show it is ignored.
    task automatic txn(input int id, input logic [N-1:0] h, input logic [N-1:0] x);
        logic [2:0] e;
        logic [N-1:0] m;
        e = model(id, h, x);
        m = N'(1) << id;
        @(negedge clk);
        start_i = 1'b1; start_id_i = IDW'(id); snp_hit_i = h; snp_excl_i = x; snp_done_i = '0;
        @(negedge clk);
        start_i = 1'b0;
        #1;
        chk("R8 cleared after start", {res_shared_o, res_excl_o, res_err_o}, 3'b000);
        chk("R2/R3/R5 bus lines", {bus_shared_o, bus_excl_o, 1'b0}, {e[2], e[1], 1'b0});
        chk("R4 not done yet", {2'b00, bus_done_o}, 3'b000);
        @(negedge clk);
        snp_done_i = ~m;
        #1;
        chk("R4/R5 done with requester bit low", {2'b00, bus_done_o}, 3'b001);
        expq.push_back(e);
        @(negedge clk);
        #1;
        chk("R7 done drops after capture", {2'b00, bus_done_o}, 3'b000);
        @(negedge clk);
        snp_done_i = '0;
        @(negedge clk);
        chk("R6 result held", {res_shared_o, res_excl_o, res_err_o}, e);
    endtask

    initial begin
        #(20 * 5000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start_i = 1'b0; start_id_i = '0;
        snp_hit_i = '0; snp_excl_i = '0; snp_done_i = '1;
        repeat (3) @(negedge clk);
        // R1: reset state; R4: done is low with no open transaction.
        chk("R1 reset result", {res_valid_o, res_shared_o, res_excl_o}, 3'b000);
        chk("R1/R4 reset done/err", {1'b0, res_err_o, bus_done_o}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R4 idle done", {2'b00, bus_done_o}, 3'b000);
        snp_done_i = '0;

        txn(0, 4'b0110, 4'b0000);   // shared only
        txn(1, 4'b0010, 4'b0010);   // requester's own bits ignored
        txn(2, 4'b0000, 4'b1000);   // exclusive in another cache
        txn(0, 4'b0110, 4'b0010);   // R9: exclusive plus second holder
        txn(3, 4'b1100, 4'b0100);   // R9: requester's copy does not count
        txn(1, 4'b1001, 4'b0000);   // shared from two caches, no error

        // R4: each non-requester done bit matters, the requester's does not.
        @(negedge clk);
        start_i = 1'b1; start_id_i = 2'd3; snp_hit_i = 4'b0001; snp_excl_i = '0; snp_done_i = '0;
        @(negedge clk);
        start_i = 1'b0; snp_done_i = 4'b0011;
        #1;
        chk("R4 one snooper pending", {2'b00, bus_done_o}, 3'b000);
        expq.push_back(model(3, 4'b0001, 4'b0000));
        @(negedge clk);
        snp_done_i = 4'b0111;
        #1;
        chk("R4 all others done", {2'b00, bus_done_o}, 3'b001);
        @(negedge clk);
        snp_done_i = '0;

        // R10: start and completion in the same cycle.
        @(negedge clk);
        start_i = 1'b1; start_id_i = 2'd2; snp_hit_i = 4'b0011; snp_excl_i = 4'b0001;
        @(negedge clk);
        start_i = 1'b1; start_id_i = 2'd0; snp_done_i = '1;
        #1;
        chk("R10 done seen before start edge", {2'b00, bus_done_o}, 3'b001);
        @(negedge clk);
        start_i = 1'b0;
        #1;
        chk("R10 old result dropped", {res_valid_o, res_shared_o, res_excl_o}, 3'b000);
        chk("R10 new transaction open", {2'b00, bus_done_o}, 3'b001);
        expq.push_back(model(0, 4'b0011, 4'b0001));
        @(negedge clk);
        snp_done_i = '0;
        repeat (4) @(negedge clk);

        chk("R6 all results seen", {2'b00, expq.size() == 0}, 3'b001);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule